// File: doc/BRIEF.md
# SPI Flash Command Opcode Dispatcher

This block sits behind the byte deserializer of an SPI flash target. It looks at the first byte of each transaction, which is the command opcode, and compares it against a table of programmable command slots. Each slot carries an enable bit, an 8-bit opcode and a 2-bit read-pipeline attribute. The matching slot decides the command class. A small state machine then enters the state for that class and holds it for the rest of the transaction. The block drives a one-hot datapath select so that exactly one downstream engine (or none) owns the transaction.

The block works in two modes. In flash mode the block itself serves status, identification and discoverable-parameter reads. In passthrough mode those three classes are served locally only when their intercept enable is set. Otherwise they fall into a wait state and leave the bus to the downstream device. When a command is intercepted, a registered intercept flag reports it. The attribute of the matched slot is latched on the opcode byte. A flag is raised when that attribute requests a two-stage read pipeline.

Top module: `spi_opcode_dispatch`

## Requirements
- R1: A slot matches only when its enable bit is set and its stored opcode equals the received byte. A byte with no matching slot sends the machine to Wait with the select all zero and no intercept flag.
- R2: An opcode is evaluated only while the state is Idle, the mode is active (mode 1 = flash, mode 2 = passthrough; codes 0 and 3 are inactive) and the byte strobe is high. Otherwise the state stays Idle.
- R3: Slot layout: 0 to 2 status reads, 3 identification read, 4 parameter read, 5 enter 4-byte, 6 exit 4-byte, 7 write enable, 8 write disable, then NumRead generic read slots, then NumUpload upload slots. When several slots match, the lowest index wins.
- R4: In flash mode, the status, identification and parameter reads go to states Status (code 1), Jedec (code 2) and Sfdp (code 3). They set select bits 0, 1 and 2 and raise no intercept flag, whatever the intercept enables.
- R5: In passthrough mode, each of those three classes goes to its own state and select bit, and raises its intercept flag, only when its intercept enable is set. Otherwise it goes to Wait (code 8) with the select at zero.
- R6: Enter 4-byte and exit 4-byte both go to Addr4B (code 6) with select bits 5 and 6. Write enable and write disable both go to WrEn (code 7) with select bits 8'h7 and 8. These apply in either mode.
- R7: Generic read slots go to ReadCmd (code 4) with select bit 3. Upload slots go to Upload (code 5) with select bit 4. These apply in either mode.
- R8: The matched slot's pipeline attribute is latched on the opcode byte. The two-stage flag is high when the attribute is 2 or 3, and low for 0 or 1 or when nothing matched.
- R9: A non-Idle state, its select, its flags and the attribute hold, ignoring further bytes, until the chip-select-release input is high. At the next edge the state returns to Idle (code 0) and all outputs clear. Release also wins over an opcode in the same cycle.
- R10: The active-low asynchronous reset forces Idle and clears the select, the intercept flags and the two-stage flag at once, without a clock.
- R11: The select is one-hot or zero, at most one intercept flag is high, and the state is never unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 off, 1 flash, 2 passthrough, 3 off |
| byteValid | input | 1 | Received byte strobe |
| byteIn | input | 8 | Received byte |
| csEnd | input | 1 | Chip select released this cycle |
| intcptStatusEn | input | 1 | Passthrough intercept enable, status reads |
| intcptJedecEn | input | 1 | Passthrough intercept enable, identification read |
| intcptSfdpEn | input | 1 | Passthrough intercept enable, parameter read |
| slotValid | input | NumSlots | Per-slot enable |
| slotOpcode | input | NumSlots*8 | Slot opcodes, slot g in bits g*8 +: 8 |
| slotPipe | input | NumSlots*2 | Slot pipeline attribute, slot g in bits g*2 +: 2 |
| cmdState | output | 4 | Current state code |
| dpSel | output | 9 | One-hot datapath select |
| intcptStatus | output | 1 | Status read intercepted |
| intcptJedec | output | 1 | Identification read intercepted |
| intcptSfdp | output | 1 | Parameter read intercepted |
| pipeTwoStage | output | 1 | Latched attribute asks for a two-stage pipeline |

## Verification
Every result of this block is registered once. The state, select, intercept flags and two-stage flag all change at the edge that samples the opcode byte or the release strobe, and reset acts with no edge at all. The driver pushes one expected output record per driven cycle. The monitor pops that record one nanosecond after the following rising edge and compares the whole output bundle, so every cycle of a transaction is checked, including the held cycles and the release. The asynchronous reset is checked directly, between clock edges, with the expectation queue empty.

// File: rtl/spi_disp_pkg.sv
package spi_disp_pkg;

  typedef enum logic [3:0] {
    StIdle    = 4'd0,
    StStatus  = 4'd1,
    StJedec   = 4'd2,
    StSfdp    = 4'd3,
    StReadCmd = 4'd4,
    StUpload  = 4'd5,
    StAddr4B  = 4'd6,
    StWrEn    = 4'd7,
    StWait    = 4'd8
  } dispState_e;

  localparam int NumDp    = 9;
  localparam int DpStatus = 0;
  localparam int DpJedec  = 1;
  localparam int DpSfdp   = 2;
  localparam int DpRead   = 3;
  localparam int DpUpload = 4;
  localparam int DpEn4B   = 5;
  localparam int DpEx4B   = 6;
  localparam int DpWrEn   = 7;
  localparam int DpWrDi   = 8;

  localparam int SlotJedec    = 3;
  localparam int SlotSfdp     = 4;
  localparam int SlotEn4B     = 5;
  localparam int SlotEx4B     = 6;
  localparam int SlotWrEn     = 7;
  localparam int SlotWrDi     = 8;
  localparam int SlotReadBase = 9;

  localparam logic [1:0] ModeFlash = 2'd1;
  localparam logic [1:0] ModePass  = 2'd2;

  localparam logic [1:0] PipeTwoHalf = 2'd2;
  localparam logic [1:0] PipeTwoFull = 2'd3;

  typedef struct packed {
    logic evalNow;
    logic dropCmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/disp_match.sv
module disp_match
  import spi_disp_pkg::*;
#(
  parameter int NumSlots = 17,
  parameter int IdxW     = $clog2(NumSlots)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            byteIn,
  input  logic [NumSlots-1:0]   slotValid,
  input  logic [NumSlots*8-1:0] slotOpcode,
  input  logic [NumSlots*2-1:0] slotPipe,
  input  ctrlStrobe_t           strobe,
  output logic                  hitAny,
  output logic [IdxW-1:0]       hitIdx,
  output logic                  twoStage
);

  logic [NumSlots-1:0] slotHit;
  logic [1:0]          pipeQ;

  for (genvar g = 0; g < NumSlots; g++) begin : gSlotCmp
    assign slotHit[g] = slotValid[g] && (slotOpcode[g*8 +: 8] == byteIn);
  end

  // Lowest index wins: scan from the top so the last hit written is the lowest.
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = NumSlots - 1; i >= 0; i--) begin
      if (slotHit[i]) begin
        hitAny = 1'b1;
        hitIdx = IdxW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ <= '0;
    end else if (strobe.dropCmd) begin
      pipeQ <= '0;
    end else if (strobe.evalNow) begin
      pipeQ <= hitAny ? slotPipe[int'(hitIdx)*2 +: 2] : 2'd0;
    end
  end

  assign twoStage = (pipeQ == PipeTwoHalf) || (pipeQ == PipeTwoFull);

  AST_ATTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.evalNow && !strobe.dropCmd |=> $stable(pipeQ)); // R8
  AST_ATTR_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropCmd |=> !twoStage); // R9

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import spi_disp_pkg::*;
#(
  parameter int NumSlots = 17,
  parameter int NumRead  = 6,
  parameter int IdxW     = $clog2(NumSlots)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             byteValid,
  input  logic             csEnd,
  input  logic             enStatus,
  input  logic             enJedec,
  input  logic             enSfdp,
  input  logic             hitAny,
  input  logic [IdxW-1:0]  hitIdx,
  output ctrlStrobe_t      strobe,
  output dispState_e       state,
  output logic [NumDp-1:0] dpSel,
  output logic [2:0]       flags
);

  localparam int ReadEnd = SlotReadBase + NumRead;

  dispState_e       nState;
  logic [NumDp-1:0] nSel;
  logic [2:0]       nFlag;
  logic             active;
  logic             inFlash;

  assign inFlash        = (mode == ModeFlash);
  assign active         = inFlash || (mode == ModePass);
  assign strobe.evalNow = (state == StIdle) && active && byteValid && !csEnd;
  assign strobe.dropCmd = csEnd;

  always_comb begin
    nState = StWait;
    nSel   = '0;
    nFlag  = '0;
    if (hitAny) begin
      if (hitIdx < IdxW'(SlotJedec)) begin
        if (inFlash || enStatus) begin
          nState = StStatus; nSel[DpStatus] = 1'b1; nFlag[0] = !inFlash;
        end
      end else if (hitIdx == IdxW'(SlotJedec)) begin
        if (inFlash || enJedec) begin
          nState = StJedec; nSel[DpJedec] = 1'b1; nFlag[1] = !inFlash;
        end
      end else if (hitIdx == IdxW'(SlotSfdp)) begin
        if (inFlash || enSfdp) begin
          nState = StSfdp; nSel[DpSfdp] = 1'b1; nFlag[2] = !inFlash;
        end
      end else if (hitIdx == IdxW'(SlotEn4B)) begin
        nState = StAddr4B; nSel[DpEn4B] = 1'b1;
      end else if (hitIdx == IdxW'(SlotEx4B)) begin
        nState = StAddr4B; nSel[DpEx4B] = 1'b1;
      end else if (hitIdx == IdxW'(SlotWrEn)) begin
        nState = StWrEn; nSel[DpWrEn] = 1'b1;
      end else if (hitIdx == IdxW'(SlotWrDi)) begin
        nState = StWrEn; nSel[DpWrDi] = 1'b1;
      end else if (hitIdx < IdxW'(ReadEnd)) begin
        nState = StReadCmd; nSel[DpRead] = 1'b1;
      end else begin
        nState = StUpload; nSel[DpUpload] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= StIdle;
      dpSel <= '0;
      flags <= '0;
    end else if (strobe.dropCmd) begin
      state <= StIdle;
      dpSel <= '0;
      flags <= '0;
    end else if (strobe.evalNow) begin
      state <= nState;
      dpSel <= nSel;
      flags <= nFlag;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dpSel)); // R11
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags)); // R11
  AST_STATE_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(state)); // R11
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    state == StWait |-> dpSel == '0 && flags == '0); // R1
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    state == StIdle && !(mode == ModeFlash || mode == ModePass) |=> state == StIdle); // R2
  AST_FLASH_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    state == StIdle && mode == ModeFlash |=> flags == '0); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    state != StIdle && !csEnd |=> $stable(state) && $stable(dpSel) && $stable(flags)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    csEnd |=> state == StIdle && dpSel == '0 && flags == '0); // R9

endmodule

// File: rtl/spi_opcode_dispatch.sv
module spi_opcode_dispatch
  import spi_disp_pkg::*;
#(
  parameter int NumRead   = 6,
  parameter int NumUpload = 2,
  parameter int NumSlots  = SlotReadBase + NumRead + NumUpload
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            mode,
  input  logic                  byteValid,
  input  logic [7:0]            byteIn,
  input  logic                  csEnd,
  input  logic                  intcptStatusEn,
  input  logic                  intcptJedecEn,
  input  logic                  intcptSfdpEn,
  input  logic [NumSlots-1:0]   slotValid,
  input  logic [NumSlots*8-1:0] slotOpcode,
  input  logic [NumSlots*2-1:0] slotPipe,
  output logic [3:0]            cmdState,
  output logic [NumDp-1:0]      dpSel,
  output logic                  intcptStatus,
  output logic                  intcptJedec,
  output logic                  intcptSfdp,
  output logic                  pipeTwoStage
);

  localparam int IdxW = $clog2(NumSlots);

  ctrlStrobe_t     strobe;
  logic            hitAny;
  logic [IdxW-1:0] hitIdx;
  dispState_e      state;
  logic [2:0]      flags;

  disp_match #(.NumSlots(NumSlots), .IdxW(IdxW)) uMatch (
    .clk       (clk),
    .rstN      (rstN),
    .byteIn    (byteIn),
    .slotValid (slotValid),
    .slotOpcode(slotOpcode),
    .slotPipe  (slotPipe),
    .strobe    (strobe),
    .hitAny    (hitAny),
    .hitIdx    (hitIdx),
    .twoStage  (pipeTwoStage)
  );

  disp_ctrl #(.NumSlots(NumSlots), .NumRead(NumRead), .IdxW(IdxW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .byteValid(byteValid),
    .csEnd    (csEnd),
    .enStatus (intcptStatusEn),
    .enJedec  (intcptJedecEn),
    .enSfdp   (intcptSfdpEn),
    .hitAny   (hitAny),
    .hitIdx   (hitIdx),
    .strobe   (strobe),
    .state    (state),
    .dpSel    (dpSel),
    .flags    (flags)
  );

  assign cmdState     = state;
  assign intcptStatus = flags[0];
  assign intcptJedec  = flags[1];
  assign intcptSfdp   = flags[2];

endmodule

// File: tb/spi_opcode_dispatch_test.sv
`timescale 1ns/100ps
module spi_opcode_dispatch_test;

  localparam int NS = 17;

  typedef struct packed {
    logic [3:0] st;
    logic [8:0] sel;
    logic [2:0] fl;
    logic       two;
  } exp_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic            byteValid = 1'b0;
  logic [7:0]      byteIn = 8'h00;
  logic            csEnd = 1'b0;
  logic            enS = 1'b0, enJ = 1'b0, enP = 1'b0;
  logic [NS-1:0]   slotValid;
  logic [NS*8-1:0] slotOpcode;
  logic [NS*2-1:0] slotPipe;
  logic [3:0]      cmdState;
  logic [8:0]      dpSel;
  logic            iS, iJ, iP, two;

  int checks = 0;
  int errors = 0;
  exp_t  expQ[$];
  string tagQ[$];
  localparam exp_t Idle = '{st: 4'd0, sel: 9'd0, fl: 3'd0, two: 1'b0};

  spi_opcode_dispatch uut (
    .clk(clk), .rstN(rstN), .mode(mode), .byteValid(byteValid), .byteIn(byteIn),
    .csEnd(csEnd), .intcptStatusEn(enS), .intcptJedecEn(enJ), .intcptSfdpEn(enP),
    .slotValid(slotValid), .slotOpcode(slotOpcode), .slotPipe(slotPipe),
    .cmdState(cmdState), .dpSel(dpSel), .intcptStatus(iS), .intcptJedec(iJ),
    .intcptSfdp(iP), .pipeTwoStage(two)
  );

  always #2 clk = ~clk;

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a = '{st: cmdState, sel: dpSel, fl: {iP, iJ, iS}, two: two};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got st=%0d sel=%b fl=%b two=%b, expected st=%0d sel=%b fl=%b two=%b",
               tag, a.st, a.sel, a.fl, a.two, e.st, e.sel, e.fl, e.two);
    end
  endtask

  // Monitor: each record is due one edge after the cycle that pushed it.
  always @(posedge clk) begin
    if (expQ.size() != 0) begin
      #1;
      compare(expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic step(input logic [1:0] m, input logic v, input logic [7:0] b,
                      input logic cs, input exp_t e, input string tag);
    @(negedge clk);
    mode = m; byteValid = v; byteIn = b; csEnd = cs;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  function automatic exp_t mk(input int st, input int bitNo, input logic [2:0] fl, input logic tw);
    exp_t e;
    e.st = 4'(st);
    e.sel = (bitNo < 0) ? 9'd0 : 9'(1 << bitNo);
    e.fl = fl;
    e.two = tw;
    return e;
  endfunction

  // Opcode, then an ignored byte, then release.
  task automatic txn(input logic [1:0] m, input logic [7:0] op, input exp_t e, input string tag);
    step(m, 1'b1, op, 1'b0, e, tag);
    step(m, 1'b1, 8'h06, 1'b0, e, {tag, " held R9"});
    step(m, 1'b0, 8'h00, 1'b1, Idle, {tag, " release R9"});
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setSlot(input int g, input logic v, input logic [7:0] op, input logic [1:0] p);
    slotValid[g] = v;
    slotOpcode[g*8 +: 8] = op;
    slotPipe[g*2 +: 2] = p;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    slotValid = '0; slotOpcode = '0; slotPipe = '0;
    setSlot(0, 1, 8'h05, 2'd0); setSlot(1, 1, 8'h35, 2'd0); setSlot(2, 1, 8'h15, 2'd0);
    setSlot(3, 1, 8'h9F, 2'd0); setSlot(4, 1, 8'h5A, 2'd0);
    setSlot(5, 1, 8'hB7, 2'd0); setSlot(6, 1, 8'hE9, 2'd0);
    setSlot(7, 1, 8'h06, 2'd0); setSlot(8, 1, 8'h04, 2'd0);
    setSlot(9, 1, 8'h03, 2'd0); setSlot(10, 1, 8'h0B, 2'd2); setSlot(11, 1, 8'h3B, 2'd3);
    setSlot(12, 1, 8'h6B, 2'd1); setSlot(13, 0, 8'hBB, 2'd3); setSlot(14, 1, 8'h0B, 2'd0);
    setSlot(15, 1, 8'h02, 2'd3); setSlot(16, 1, 8'h03, 2'd0);

    #7;
    compare(Idle, "R10 reset state");
    @(negedge clk); rstN = 1'b1;

    // R4: flash mode, own states, no flags even with enables on.
    txn(2'd1, 8'h05, mk(1, 0, 3'b000, 0), "R4 status0 flash");
    txn(2'd1, 8'h35, mk(1, 0, 3'b000, 0), "R4 status1 flash");
    txn(2'd1, 8'h9F, mk(2, 1, 3'b000, 0), "R4 jedec flash");
    txn(2'd1, 8'h5A, mk(3, 2, 3'b000, 0), "R4 sfdp flash");
    drain(); enS = 1; enJ = 1; enP = 1;
    txn(2'd1, 8'h05, mk(1, 0, 3'b000, 0), "R4 status flash enables set");
    drain(); enS = 0; enJ = 0; enP = 0;

    // R5: passthrough, intercept gated by enables.
    txn(2'd2, 8'h05, mk(8, -1, 3'b000, 0), "R5 status pass no enable");
    txn(2'd2, 8'h9F, mk(8, -1, 3'b000, 0), "R5 jedec pass no enable");
    txn(2'd2, 8'h5A, mk(8, -1, 3'b000, 0), "R5 sfdp pass no enable");
    drain(); enS = 1;
    txn(2'd2, 8'h15, mk(1, 0, 3'b001, 0), "R5 status pass intercept");
    txn(2'd2, 8'h9F, mk(8, -1, 3'b000, 0), "R5 jedec pass only status enabled");
    drain(); enS = 0; enJ = 1;
    txn(2'd2, 8'h9F, mk(2, 1, 3'b010, 0), "R5 jedec pass intercept");
    drain(); enJ = 0; enP = 1;
    txn(2'd2, 8'h5A, mk(3, 2, 3'b100, 0), "R5 sfdp pass intercept");
    drain(); enP = 0;

    // R6: address mode and write enable groups.
    txn(2'd1, 8'hB7, mk(6, 5, 3'b000, 0), "R6 enter 4-byte");
    txn(2'd1, 8'hE9, mk(6, 6, 3'b000, 0), "R6 exit 4-byte");
    txn(2'd1, 8'h06, mk(7, 7, 3'b000, 0), "R6 write enable");
    txn(2'd1, 8'h04, mk(7, 8, 3'b000, 0), "R6 write disable");
    txn(2'd2, 8'hB7, mk(6, 5, 3'b000, 0), "R6 enter 4-byte pass");

    // R7/R8/R3: generic reads, attributes, priority, upload.
    txn(2'd1, 8'h03, mk(4, 3, 3'b000, 0), "R3 R7 read beats upload slot");
    txn(2'd1, 8'h0B, mk(4, 3, 3'b000, 1), "R3 R8 lowest read slot attribute");
    txn(2'd1, 8'h3B, mk(4, 3, 3'b000, 1), "R8 two-stage full");
    txn(2'd1, 8'h6B, mk(4, 3, 3'b000, 0), "R8 single stage");
    txn(2'd1, 8'hBB, mk(8, -1, 3'b000, 0), "R1 disabled slot");
    txn(2'd1, 8'hAA, mk(8, -1, 3'b000, 0), "R1 unknown opcode");
    txn(2'd1, 8'h02, mk(5, 4, 3'b000, 1), "R7 upload flash");
    txn(2'd2, 8'h02, mk(5, 4, 3'b000, 1), "R7 upload pass");

    // R2: inactive modes and missing strobe.
    step(2'd0, 1'b1, 8'h05, 1'b0, Idle, "R2 mode off");
    step(2'd3, 1'b1, 8'h05, 1'b0, Idle, "R2 mode reserved");
    step(2'd1, 1'b0, 8'h05, 1'b0, Idle, "R2 no strobe");
    // R9: release wins over an opcode in the same cycle.
    step(2'd1, 1'b1, 8'h05, 1'b1, Idle, "R9 release with opcode");
    step(2'd1, 1'b0, 8'h00, 1'b0, Idle, "R9 idle after release");

    // R10: asynchronous reset mid-command.
    step(2'd1, 1'b1, 8'h0B, 1'b0, mk(4, 3, 3'b000, 1), "R10 command before reset");
    step(2'd1, 1'b0, 8'h00, 1'b0, mk(4, 3, 3'b000, 1), "R10 command held");
    drain();
    #1 rstN = 1'b0;
    #0.5;
    compare(Idle, "R10 async reset");
    @(negedge clk); rstN = 1'b1;
    step(2'd1, 1'b0, 8'h00, 1'b0, Idle, "R10 idle after reset");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule